// File: doc/BRIEF.md
# Bridge Destination Address Filter

This block sits beside the Ethernet receive controller of a MAC-level bridge. The controller is set to accept every frame. The filter watches the same serial receive bit stream. It shifts the first 48 bits of each frame into a capture register; these bits are the destination address. It then compares that address with a table of known stations in one clock cycle. Each table entry marks its station as local or remote. A frame addressed to a remote station is left alone, so the controller goes on to receive it for forwarding.

A frame addressed to a local station, or to no known station at all, must not be kept. For such a frame the filter raises a collision indication towards the controller. The controller then drops the frame and goes back to hunting for the next one. It writes nothing into its buffers and raises no interrupt. The decision falls in the few bit times between the end of the address and the start of the payload.

Management logic loads and clears table entries through a simple write port. A write that arrives in the lookup cycle is held back and applied one cycle later. A lookup therefore never sees an entry that is being changed.

Top module: `bridge_addr_filter`

## Requirements
- R1: After reset every table entry is invalid and `col_det` is low, so the first complete frame is rejected whatever its address.
- R2: While `rx_valid` is high, the first bit received is taken as address bit 0 and the 48th as bit 47. The lookup occupies the cycle after the edge that samples the 48th bit. `col_det` can rise only at the clock edge after that lookup cycle.
- R3: A captured address that matches no valid entry asserts `col_det`.
- R4: A captured address that matches a valid entry tagged local (tag 0) asserts `col_det`.
- R5: A captured address that matches a valid entry tagged remote (tag 1) leaves `col_det` low for the whole frame.
- R6: Once raised, `col_det` stays high for exactly `COL_HOLD` clock cycles and then falls. It rises at most once per frame.
- R7: When several valid entries hold the captured address, the entry with the lowest index alone decides local or remote.
- R8: A write with `wr_valid` = 0 removes the entry at `wr_idx` from matching. A later write with `wr_valid` = 1 restores it.
- R9: A table write presented in the lookup cycle does not affect that lookup. It takes effect from the following cycle and is not lost.
- R10: A frame in which `rx_valid` falls before 48 bits have arrived causes no lookup and no `col_det`. The bit count restarts at zero for the next frame.
- R11: Bits received after the 48th, up to the fall of `rx_valid`, have no influence on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | High while a frame's bits are arriving |
| rx_bit | input | 1 | Serial receive data, sampled when `rx_valid` is high |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(DEPTH) | Entry index to write |
| wr_valid | input | 1 | Valid bit stored with the entry (0 invalidates) |
| wr_remote | input | 1 | Tag stored with the entry: 1 remote, 0 local |
| wr_mac | input | 48 | Station address stored with the entry |
| col_det | output | 1 | Collision indication to the receive controller |

## Verification
The bench aims at the exact cycle in which `col_det` rises and falls. A design that looks up one cycle early or late, or that holds the pulse one cycle too long or too short, fails the per-cycle comparison over every frame. Every pair of entries is loaded with one shared address and opposite tags, so priority logic that favours the higher index, or that merges the tags of all hits, inverts the result. A frame carrying the bit-reversed form of a stored address exposes a capture that shifts in the wrong direction.

Three further cases target the edges of the capture and write logic. A write issued in the lookup cycle catches a table that takes the write at once, or one that drops a blocked write. A runt frame followed by a full frame catches a bit counter that is not cleared when `rx_valid` falls. The payload bits of each frame hold other addresses and catch a design that keeps shifting after the 48th bit.

// File: rtl/bf_pkg.sv
package bf_pkg;

    // width of a station address on the wire
    localparam int MAC_W = 48;

    // capture sequencer: armed while collecting address bits, parked
    // after the address until the frame ends
    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_PARKED = 1'b1
    } cap_st_e;

endpackage

// File: rtl/bf_capture.sv
module bf_capture
    import bf_pkg::*;
#(
    parameter int AW = MAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_bit,
    output logic [AW-1:0] dest,
    output logic          look_go
);

    localparam int CW = $clog2(AW);

    typedef struct packed {
        cap_st_e       st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] sh;
        logic          go;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.go = 1'b0;
        case (cap_q.st)
            CAP_ARMED: begin
                if (rx_valid) begin
                    // first bit on the wire ends up in bit 0
                    cap_d.sh = {rx_bit, cap_q.sh[AW-1:1]};
                    if (cap_q.cnt == CW'(AW - 1)) begin
                        cap_d.go  = 1'b1;
                        cap_d.cnt = '0;
                        cap_d.st  = CAP_PARKED;
                    end else begin
                        cap_d.cnt = cap_q.cnt + CW'(1);
                    end
                end else begin
                    // runt frame or idle line: start counting afresh
                    cap_d.cnt = '0;
                end
            end
            CAP_PARKED: begin
                if (!rx_valid) begin
                    cap_d.st = CAP_ARMED;
                end
            end
            default: cap_d.st = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign dest    = cap_q.sh;
    assign look_go = cap_q.go;

endmodule

// File: rtl/bf_cam.sv
module bf_cam
    import bf_pkg::*;
#(
    parameter int AW    = MAC_W,
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_valid,
    input  logic          wr_remote,
    input  logic [AW-1:0] wr_mac,
    input  logic          look_en,
    input  logic [AW-1:0] key,
    output logic          hit,
    output logic          hit_remote
);

    typedef struct packed {
        logic          vld;
        logic          rem;
        logic [AW-1:0] mac;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] tab;
        logic             pend_v;
        logic [IW-1:0]    pend_idx;
        ent_t             pend_e;
    } cam_t;

    cam_t cam_d, cam_q;
    ent_t wr_ent;

    assign wr_ent = '{vld: wr_valid, rem: wr_remote, mac: wr_mac};

    always_comb begin
        cam_d        = cam_q;
        cam_d.pend_v = 1'b0;
        // a write held back during the last lookup lands now
        if (cam_q.pend_v && (int'(cam_q.pend_idx) < DEPTH)) begin
            cam_d.tab[cam_q.pend_idx] = cam_q.pend_e;
        end
        if (wr_en) begin
            if (look_en) begin
                cam_d.pend_v   = 1'b1;
                cam_d.pend_idx = wr_idx;
                cam_d.pend_e   = wr_ent;
            end else if (int'(wr_idx) < DEPTH) begin
                // a newer write to the same slot overrides the pending one
                cam_d.tab[wr_idx] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cam_q <= '0;
        end else begin
            cam_q <= cam_d;
        end
    end

    // one comparator per entry
    logic [DEPTH-1:0] match;
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
        assign match[gi] = cam_q.tab[gi].vld && (cam_q.tab[gi].mac == key);
    end

    // the lowest matching index decides the tag
    logic sel_rem;
    always_comb begin
        sel_rem = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_rem = cam_q.tab[i].rem;
            end
        end
    end

    assign hit        = |match;
    assign hit_remote = sel_rem;

endmodule

// File: rtl/bf_colgen.sv
module bf_colgen #(
    parameter int HOLD = 32,
    localparam int HW  = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic reject,
    output logic col
);

    typedef struct packed {
        logic          on;
        logic [HW-1:0] left;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (col_q.on) begin
            if (col_q.left == HW'(1)) begin
                col_d.on = 1'b0;
            end
            col_d.left = col_q.left - HW'(1);
        end else if (go && reject) begin
            col_d.on   = 1'b1;
            col_d.left = HW'(HOLD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign col = col_q.on;

endmodule

// File: rtl/bridge_addr_filter.sv
module bridge_addr_filter
    import bf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int COL_HOLD = 32,
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic             wr_remote,
    input  logic [MAC_W-1:0] wr_mac,
    output logic             col_det
);

    logic [MAC_W-1:0] dest_w;
    logic             look_go;
    logic             hit_w;
    logic             hit_rem_w;
    logic             reject_w;

    bf_capture #(.AW(MAC_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .dest     (dest_w),
        .look_go  (look_go)
    );

    bf_cam #(.AW(MAC_W), .DEPTH(DEPTH)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_valid   (wr_valid),
        .wr_remote  (wr_remote),
        .wr_mac     (wr_mac),
        .look_en    (look_go),
        .key        (dest_w),
        .hit        (hit_w),
        .hit_remote (hit_rem_w)
    );

    // unknown or local stations are dropped
    assign reject_w = !hit_w || !hit_rem_w;

    bf_colgen #(.HOLD(COL_HOLD)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (look_go),
        .reject (reject_w),
        .col    (col_det)
    );

endmodule

// File: rtl/bf_checker.sv
module bf_checker #(
    parameter int HOLD = 32,
    localparam int RW  = $clog2(HOLD + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic col_det,
    input logic look_go,
    input logic reject
);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (col_det) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_LOOKUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        look_go |=> !look_go); // R2

    AST_COL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_det) |-> $past(look_go && reject)); // R3

    AST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (look_go && !reject && !col_det) |=> !col_det); // R5

    AST_COL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_det) |-> (run_q == RW'(HOLD))); // R6

    AST_COL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        col_det |-> (run_q < RW'(HOLD))); // R6

endmodule

bind bridge_addr_filter bf_checker #(.HOLD(COL_HOLD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_det (col_det),
    .look_go (look_go),
    .reject  (reject_w)
);

// File: tb/bridge_addr_filter_test.sv
`timescale 1ns/1ps
module bridge_addr_filter_test;

    localparam int DEPTH = 8;
    localparam int HOLD  = 6;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_bit = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic          wr_remote = 1'b0;
    logic [47:0]   wr_mac = '0;
    logic          col_det;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bridge_addr_filter #(.DEPTH(DEPTH), .COL_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_remote(wr_remote), .wr_mac(wr_mac), .col_det(col_det)
    );

    function automatic logic [47:0] addr_of(int i);
        return 48'h0A1B_2C00_0000 ^ (48'(i) * 48'h0000_1357_9BDF) ^ 48'(i + 3);
    endfunction

    function automatic logic [47:0] bitrev(logic [47:0] a);
        logic [47:0] r;
        for (int k = 0; k < 48; k++) r[k] = a[47-k];
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tab_wr(int idx, bit vld, bit rem, logic [47:0] mac);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = vld;
        wr_remote = rem; wr_mac = mac;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // sends one full frame and compares col_det in every cycle after the
    // address; optionally issues a table write in the lookup cycle
    task automatic frame(logic [47:0] mac, bit exp_rej, string req,
                         bit do_wr = 1'b0, int w_idx = 0, bit w_rem = 1'b0,
                         logic [47:0] w_mac = '0);
        int errs = 0;
        int first_j = -1;
        int first_act = 0;
        int first_exp = 0;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_bit = mac[k];
        end
        for (int j = 0; j <= HOLD + 6; j++) begin
            bit e;
            @(negedge clk);
            if (do_wr && j == 0) begin
                wr_en = 1'b1; wr_idx = IW'(w_idx); wr_valid = 1'b1;
                wr_remote = w_rem; wr_mac = w_mac;
            end
            if (j == 1) wr_en = 1'b0;
            rx_bit = ~mac[j % 48]; // payload bits: R11
            e = exp_rej && (j >= 1) && (j <= HOLD);
            if (col_det !== e) begin
                errs++;
                if (first_j < 0) begin
                    first_j = j; first_act = int'(col_det); first_exp = int'(e);
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (errs != 0)
            $display("  frame %h first bad cycle %0d after address", mac, first_j);
        check(errs == 0, req, first_act, first_exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(col_det == 1'b0, "R1 reset col_det", int'(col_det), 0);

        // empty table rejects everything
        frame(addr_of(0), 1'b1, "R1 empty table");

        // load all entries, odd index remote
        for (int i = 0; i < DEPTH; i++) tab_wr(i, 1'b1, i[0], addr_of(i));
        for (int i = 0; i < DEPTH; i++)
            frame(addr_of(i), !i[0], i[0] ? "R5 R11 remote passes" : "R4 R6 local rejected");
        for (int u = 0; u < 4; u++)
            frame(addr_of(DEPTH + 10 + u), 1'b1, "R3 unknown rejected");

        // capture order: reversed image of a remote entry is unknown
        frame(bitrev(addr_of(1)), 1'b1, "R2 bit order");
        frame(addr_of(1), 1'b0, "R2 bit order forward");

        // priority sweep over every pair with opposite tags
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = i + 1; j < DEPTH; j++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [47:0] p;
                    p = 48'hF00D_0000_0000 | 48'(i * 16 + j);
                    tab_wr(i, 1'b1, t[0], p);
                    tab_wr(j, 1'b1, !t[0], p);
                    frame(p, !t[0], "R7 lowest index wins");
                end
                tab_wr(i, 1'b1, i[0], addr_of(i));
                tab_wr(j, 1'b1, j[0], addr_of(j));
            end
        end

        // invalidate and restore a remote entry
        tab_wr(3, 1'b0, 1'b1, addr_of(3));
        frame(addr_of(3), 1'b1, "R8 invalidated entry");
        tab_wr(3, 1'b1, 1'b1, addr_of(3));
        frame(addr_of(3), 1'b0, "R8 restored entry");

        // write in the lookup cycle: old remote tag decides, new tag later
        frame(addr_of(5), 1'b0, "R9 lookup uses old entry", 1'b1, 5, 1'b0, addr_of(5));
        frame(addr_of(5), 1'b1, "R9 deferred write applied");
        tab_wr(5, 1'b1, 1'b1, addr_of(5));

        // runt frame: 30 bits then idle
        begin
            int seen = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                rx_valid = 1'b1;
                rx_bit = addr_of(0)[k];
            end
            @(negedge clk);
            rx_valid = 1'b0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (col_det) seen++;
            end
            check(seen == 0, "R10 runt no collision", seen, 0);
        end
        frame(addr_of(7), 1'b0, "R10 full frame after runt");
        frame(addr_of(6), 1'b1, "R10 R6 local after runt");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule